// File: doc/BRIEF.md
# Lowest-Priority Interrupt Distributor

This block sits between interrupt sources and a small cluster of processors. Each request carries a vector and a delivery mode. The block turns the request into a target mask over the processors. Fixed delivery names one processor. Broadcast delivery reaches every processor that is switched on. Lowest-priority delivery picks the enabled processor whose current task priority is smallest.

Each processor supplies a 4-bit task priority, where 0 is the least busy. A per-processor enable mask removes processors from consideration. When several enabled processors share the smallest priority, a rotating pointer decides between them, so that repeated ties spread the work around the cluster. The pointer moves only after such a tie, to the slot just past the winner.

A request is accepted on a valid/ready handshake. The routing result, a mask with a strobe and the echoed vector, comes out of registers on the next clock. A fixed request aimed at a processor that cannot take it is dropped and sets a sticky error flag.

Top module: `lp_irq_router`

## Requirements
- R1: `req_ready` is always high. A request accepted at a clock edge gives its result on `out_valid`/`out_mask` right after that edge. A cycle with no request leaves `out_valid` low and `out_mask` zero after the next edge.
- R2: `req_mode` encoding: 2'b00 fixed, 2'b01 lowest priority, 2'b10 broadcast, 2'b11 reserved. A reserved request produces no strobe, a zero mask and no change to the error flag.
- R3: Fixed delivery to an enabled processor `req_dest` gives `out_valid`=1 and a mask with only bit `req_dest` set.
- R4: Fixed delivery to a disabled processor, or to an index of N or above, gives no strobe and sets `err_flag`. The flag stays set until reset.
- R5: Broadcast delivery gives a mask equal to `proc_en`, with the strobe only when that mask is non-zero.
- R6: Lowest-priority delivery gives a one-hot mask naming an enabled processor whose priority field (`proc_prio[4*i+3:4*i]` for processor i) is numerically smallest among the enabled processors.
- R7: When more than one enabled processor holds that smallest value, the winner is the first of them found by scanning upward from the rotation pointer, wrapping past N-1 to 0. The pointer then moves to winner+1, modulo N.
- R8: A lowest-priority request with a single smallest processor leaves the rotation pointer unchanged.
- R9: With `proc_en` all zero, lowest-priority and broadcast requests produce no strobe and do not set `err_flag`.
- R10: During reset `out_valid`, `out_mask` and `err_flag` are cleared and the rotation pointer returns to processor 0.
- R11: While `out_valid` is high, `out_vector` equals the vector of the request that produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high; the block accepts a request every cycle |
| req_mode | input | 2 | Delivery mode |
| req_dest | input | IW | Processor index for fixed delivery |
| req_vector | input | VW | Interrupt vector |
| proc_en | input | N | Per-processor enable |
| proc_prio | input | N*PW | Packed task priorities, processor i in bits PW*i+PW-1 : PW*i |
| out_valid | output | 1 | Routing result strobe |
| out_mask | output | N | Target processors |
| out_vector | output | VW | Vector of the routed request |
| err_flag | output | 1 | Sticky error for a dropped fixed delivery |

## Verification
The bench drives runs of tied lowest-priority requests and checks that the winner walks around the tied set. A pointer that never moves would keep hitting one processor, and a pointer that moves after a clear winner would break the expected order. It mixes a clear minimum into the tie runs and combines disabled processors with low priorities. A design that ignored the enable mask would then route to a switched-off processor. It also covers broadcast and lowest-priority requests with every processor disabled, where a stray strobe or error would show, and it checks that the error flag survives a later good request and clears only on reset.

// File: rtl/lp_route_pkg.sv
// Package: shared delivery-mode encoding for the interrupt distributor.
// Assumes: a 2-bit mode field on the request side.
package lp_route_pkg;

    typedef enum logic [1:0] {
        DM_FIXED  = 2'b00,
        DM_LOWEST = 2'b01,
        DM_BCAST  = 2'b10,
        DM_RSVD   = 2'b11
    } dmode_e;

endpackage

// File: rtl/lp_prio_min.sv
// lp_prio_min: finds the smallest task priority among the enabled processors
// and returns a mask of every enabled processor that holds it.
// Assumes: priorities are packed PW bits per processor, processor 0 lowest.
module lp_prio_min #(
    parameter int N  = 4,
    parameter int PW = 4
) (
    input  logic [N-1:0]    en,
    input  logic [N*PW-1:0] prio,
    output logic [N-1:0]    cand,
    output logic            any
);

    logic [PW-1:0] min_val;

    // Pass 1: scan for the minimum value over enabled processors.
    always_comb begin
        min_val = '1;
        any     = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (en[i] && (!any || (prio[i*PW +: PW] < min_val))) begin
                min_val = prio[i*PW +: PW];
                any     = 1'b1;
            end
        end
    end

    // Pass 2: mark every enabled processor equal to the minimum.
    always_comb begin
        cand = '0;
        for (int i = 0; i < N; i++) begin
            cand[i] = en[i] && any && (prio[i*PW +: PW] == min_val);
        end
    end

endmodule

// File: rtl/lp_rr_pick.sv
// lp_rr_pick: picks the first set bit of a candidate mask, scanning upward
// from a rotating start index and wrapping at N.
// Assumes: ptr < N; an empty candidate mask yields an empty grant.
module lp_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx,
    output logic          tie
);

    logic found;

    // Rotating scan: first candidate at or after ptr wins.
    always_comb begin
        int idx;
        grant     = '0;
        grant_idx = '0;
        found     = 1'b0;
        for (int off = 0; off < N; off++) begin
            idx = int'(ptr) + off;
            if (idx >= N) idx = idx - N;
            if (!found && cand[idx]) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                grant_idx  = IW'(idx);
            end
        end
    end

    // A tie exists when two or more processors are candidates.
    always_comb begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < N; i++) cnt += int'(cand[i]);
        tie = (cnt > 1);
    end

endmodule

// File: rtl/lp_target_sel.sv
// lp_target_sel: turns a delivery mode plus enable state into a target mask,
// and flags fixed deliveries that cannot be honoured.
// Assumes: lp_grant is one-hot or zero.
module lp_target_sel
    import lp_route_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [1:0]    mode,
    input  logic [IW-1:0] dest,
    input  logic [N-1:0]  en,
    input  logic [N-1:0]  lp_grant,
    output logic [N-1:0]  target,
    output logic          fixed_bad
);

    logic          dest_ok;
    logic [N-1:0]  dest_onehot;

    // Decode the fixed destination and test it against the enable mask.
    always_comb begin
        dest_onehot = '0;
        dest_ok     = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (int'(dest) == i) begin
                dest_onehot[i] = 1'b1;
                dest_ok        = en[i];
            end
        end
    end

    // Mode multiplexer for the target mask and the drop error.
    always_comb begin
        target    = '0;
        fixed_bad = 1'b0;
        case (dmode_e'(mode))
            DM_FIXED: begin
                if (dest_ok) target = dest_onehot;
                else         fixed_bad = 1'b1;
            end
            DM_LOWEST: target = lp_grant;
            DM_BCAST:  target = en;
            default:   target = '0;
        endcase
    end

endmodule

// File: rtl/lp_irq_router.sv
// lp_irq_router: top of the lowest-priority interrupt distributor. Accepts one
// request per cycle and registers the routing result one cycle later.
// Assumes: N >= 2; priorities stable in the cycle the request is presented.
module lp_irq_router
    import lp_route_pkg::*;
#(
    parameter int N  = 4,
    parameter int PW = 4,
    parameter int VW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_mode,
    input  logic [IW-1:0] req_dest,
    input  logic [VW-1:0] req_vector,
    input  logic [N-1:0]  proc_en,
    input  logic [N*PW-1:0] proc_prio,
    output logic          out_valid,
    output logic [N-1:0]  out_mask,
    output logic [VW-1:0] out_vector,
    output logic          err_flag
);

    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    logic [N-1:0]  cand;
    logic          cand_any;
    logic [IW-1:0] rr_ptr;
    logic [N-1:0]  lp_grant;
    logic [IW-1:0] lp_idx;
    logic          lp_tie;
    logic [N-1:0]  target;
    logic          fixed_bad;
    logic          accept;
    logic          ptr_step;
    logic [IW-1:0] ptr_next;

    assign req_ready = 1'b1;
    assign accept    = req_valid && req_ready;

    lp_prio_min #(.N(N), .PW(PW)) u_min (
        .en   (proc_en),
        .prio (proc_prio),
        .cand (cand),
        .any  (cand_any)
    );

    lp_rr_pick #(.N(N), .IW(IW)) u_pick (
        .cand      (cand),
        .ptr       (rr_ptr),
        .grant     (lp_grant),
        .grant_idx (lp_idx),
        .tie       (lp_tie)
    );

    lp_target_sel #(.N(N), .IW(IW)) u_sel (
        .mode      (req_mode),
        .dest      (req_dest),
        .en        (proc_en),
        .lp_grant  (lp_grant),
        .target    (target),
        .fixed_bad (fixed_bad)
    );

    // Pointer step: only after a lowest-priority tie, to the slot past the winner.
    always_comb begin
        ptr_step = accept && (dmode_e'(req_mode) == DM_LOWEST) && cand_any && lp_tie;
        ptr_next = (lp_idx == LAST_IDX) ? '0 : lp_idx + IW'(1);
    end

    // Rotation pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)        rr_ptr <= '0;
        else if (ptr_step) rr_ptr <= ptr_next;
    end

    // Result registers: strobe, mask and vector one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_mask   <= '0;
            out_vector <= '0;
        end else begin
            out_valid <= accept && (|target);
            out_mask  <= accept ? target : '0;
            if (accept) out_vector <= req_vector;
        end
    end

    // Sticky error for dropped fixed deliveries.
    always_ff @(posedge clk) begin
        if (!rst_n)                      err_flag <= 1'b0;
        else if (accept && fixed_bad)    err_flag <= 1'b1;
    end

endmodule

// File: rtl/lp_route_chk.sv
// lp_route_chk: property checker for lp_irq_router, attached by bind.
// Assumes: same N and IW as the bound instance.
module lp_route_chk #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_mode,
    input logic [IW-1:0] req_dest,
    input logic [N-1:0]  proc_en,
    input logic          out_valid,
    input logic [N-1:0]  out_mask,
    input logic          err_flag
);

    logic dest_live;
    assign dest_live = (int'(req_dest) < N) && ((proc_en >> req_dest) & N'(1)) != '0;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && out_mask == '0));

    assert_rsvd_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b11) |=> (!out_valid && err_flag == $past(err_flag)));

    assert_fixed_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b00 && dest_live) |=>
            (out_valid && out_mask == (N'(1) << $past(req_dest))));

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_bcast_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b10) |=> (out_mask == $past(proc_en)));

    assert_lowest_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b01) |=>
            ($onehot0(out_mask) && (out_mask & ~$past(proc_en)) == '0));

    assert_none_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode != 2'b00 && proc_en == '0) |=>
            (!out_valid && err_flag == $past(err_flag)));

    assert_strobe_has_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_mask != '0);

endmodule

bind lp_irq_router lp_route_chk #(.N(N), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_dest  (req_dest),
    .proc_en   (proc_en),
    .out_valid (out_valid),
    .out_mask  (out_mask),
    .err_flag  (err_flag)
);

// File: tb/sim_lp_irq_router.sv
module sim_lp_irq_router;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int PW = 4;
    localparam int VW = 8;

    // Entry: {mode[31:30], dest[29:28], en[27:24], prio[23:8] (proc3..proc0), vector[7:0]}
    localparam int NV = 14;
    localparam logic [31:0] VTAB [NV] = '{
        {2'b00, 2'd2, 4'hF, 16'h1111, 8'h21},
        {2'b00, 2'd0, 4'hF, 16'h1111, 8'h22},
        {2'b10, 2'd0, 4'hF, 16'h1111, 8'h23},
        {2'b10, 2'd0, 4'h5, 16'h1111, 8'h24},
        {2'b01, 2'd0, 4'hF, 16'h4213, 8'h25},
        {2'b01, 2'd0, 4'hF, 16'h7777, 8'h26},
        {2'b01, 2'd0, 4'hF, 16'h7777, 8'h27},
        {2'b01, 2'd0, 4'hD, 16'h2050, 8'h28},
        {2'b01, 2'd0, 4'hE, 16'hFFFF, 8'h29},
        {2'b11, 2'd1, 4'hF, 16'h0000, 8'h2A},
        {2'b01, 2'd0, 4'h0, 16'h0000, 8'h2B},
        {2'b10, 2'd0, 4'h0, 16'h0000, 8'h2C},
        {2'b01, 2'd0, 4'hF, 16'h9191, 8'h2D},
        {2'b00, 2'd3, 4'h7, 16'h0000, 8'h2E}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_mode = '0;
    logic [1:0]    req_dest = '0;
    logic [VW-1:0] req_vector = '0;
    logic [N-1:0]  proc_en = '0;
    logic [N*PW-1:0] proc_prio = '0;
    logic          out_valid;
    logic [N-1:0]  out_mask;
    logic [VW-1:0] out_vector;
    logic          err_flag;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    int   m_ptr = 0;
    logic m_err = 1'b0;
    logic         e_valid;
    logic [N-1:0] e_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_irq_router #(.N(N), .PW(PW), .VW(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_dest(req_dest), .req_vector(req_vector),
        .proc_en(proc_en), .proc_prio(proc_prio), .out_valid(out_valid),
        .out_mask(out_mask), .out_vector(out_vector), .err_flag(err_flag)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Reference model, written from the requirements.
    task automatic model(input logic [1:0] mode, input logic [1:0] dest,
                         input logic [3:0] en, input logic [15:0] prio);
        int minv, cnt, w;
        e_valid = 1'b0;
        e_mask  = '0;
        case (mode)
            2'b00: begin
                if (en[dest]) begin e_mask[dest] = 1'b1; e_valid = 1'b1; end
                else m_err = 1'b1;
            end
            2'b10: begin e_mask = en; e_valid = (en != 0); end
            2'b01: begin
                minv = 16; cnt = 0; w = -1;
                for (int i = 0; i < N; i++)
                    if (en[i] && int'(prio[i*4 +: 4]) < minv) minv = int'(prio[i*4 +: 4]);
                for (int i = 0; i < N; i++)
                    if (en[i] && int'(prio[i*4 +: 4]) == minv) cnt++;
                for (int k = 0; k < N; k++) begin
                    int j;
                    j = (m_ptr + k) % N;
                    if (w < 0 && en[j] && int'(prio[j*4 +: 4]) == minv) w = j;
                end
                if (w >= 0) begin
                    e_mask[w] = 1'b1; e_valid = 1'b1;
                    if (cnt > 1) m_ptr = (w + 1) % N;
                end
            end
            default: ;
        endcase
    endtask

    task automatic send(input string req, input logic [1:0] mode, input logic [1:0] dest,
                        input logic [3:0] en, input logic [15:0] prio, input logic [7:0] vec);
        @(negedge clk);
        req_valid = 1'b1; req_mode = mode; req_dest = dest;
        proc_en = en; proc_prio = prio; req_vector = vec;
        model(mode, dest, en, prio);
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " valid"}, 32'(out_valid), 32'(e_valid));
        chk({req, " mask"},  32'(out_mask),  32'(e_mask));
        chk({req, " err"},   32'(err_flag),  32'(m_err));
        if (e_valid) chk({req, " vector R11"}, 32'(out_vector), 32'(vec));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_ptr = 0; m_err = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state
        chk("R10 out_valid", 32'(out_valid), 0);
        chk("R10 out_mask",  32'(out_mask), 0);
        chk("R10 err_flag",  32'(err_flag), 0);
        chk("R1 ready", 32'(req_ready), 1);

        // table walk: R2 R3 R5 R6 R7 R8 R9 R4
        for (int t = 0; t < NV; t++) begin
            logic [31:0] e;
            e = VTAB[t];
            send($sformatf("table[%0d] R2/R3/R5/R6/R7/R8/R9", t),
                 e[31:30], e[29:28], e[27:24], e[23:8], e[7:0]);
        end

        // R4: error persists after a valid fixed request
        send("R4 sticky after good fixed", 2'b00, 2'd1, 4'hF, 16'h0, 8'h31);
        // R1: idle cycle yields nothing
        @(negedge clk);
        chk("R1 idle valid", 32'(out_valid), 0);
        chk("R1 idle mask",  32'(out_mask), 0);

        // R10: reset clears the error and the pointer; R7 rotation over tied set 0,1,3
        do_reset();
        chk("R10 err cleared", 32'(err_flag), 0);
        for (int k = 0; k < 7; k++)
            send("R7 tie rotation", 2'b01, 2'd0, 4'hB, 16'h5555, 8'(8'h40 + k));
        // R8: unique minimum in the middle of a tie run does not move the pointer
        send("R8 unique min", 2'b01, 2'd0, 4'hF, 16'h5525, 8'h50);
        send("R7 after unique", 2'b01, 2'd0, 4'hF, 16'h5555, 8'h51);
        send("R7 after unique 2", 2'b01, 2'd0, 4'hF, 16'h5555, 8'h52);
        // R9: nothing enabled
        send("R9 lowest none", 2'b01, 2'd0, 4'h0, 16'h0, 8'h53);
        send("R9 bcast none", 2'b10, 2'd0, 4'h0, 16'h0, 8'h54);
        // R2: reserved mode
        send("R2 reserved", 2'b11, 2'd2, 4'hF, 16'h0, 8'h55);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule